// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the hazard control unit of a small four-stage, in-order pipeline (fetch, decode, execute, writeback) that takes in one instruction per clock. It sees the decoded fields of the instruction in decode and the instruction in execute. From these it drives three things: the operand forward selects for the ALU, a cancel mark for each of the three younger stages, and a command to the program counter.

Data hazards cost no cycles. When the instruction in execute writes the register that the decode instruction reads, the ALU result is routed back into that operand. This works for each operand on its own. Every operand source passes through the ALU, so forwarding applies whatever the producer's source was.

Control hazards are handled by cancelling the two younger instructions. The cases are:
- A live instruction in execute that writes flags or updates the pointer register cancels the two younger instructions and steps the program counter back by one, so they are fetched again.
- A taken branch, call or return cancels the same two instructions and loads the target.
- A transfer whose condition is false costs nothing.

A delay-slot mode input turns off all cancelling and leaves forwarding on.

Top module: `hcu_ctrl`

## Requirements
- R1: `fwd_a` is 1 exactly when the execute instruction is not cancelled, `e_reg_we` is 1 and `e_dst` equals `d_src_a`. Register index 0 gets no special treatment.
- R2: `fwd_b` follows the same rule against `d_src_b`, independently of `fwd_a`; both may be 1 together.
- R3: Forwarding works the same with `delay_slot_mode` at 1.
- R4: A live execute instruction with `e_flag_we` or `e_ptr_upd` set, in normal mode and not a taken transfer, gives the following in the same cycle:
  - `pc_cmd` = 2 (step back one);
  - `kill_if` = 1 and `kill_de` = 1.
  Those two instructions then show `kill_ex` = 1 on the next two cycles, and `kill_ex` returns to 0 on the third.
- R5: A live execute instruction is a taken transfer when `e_xfer` is not 0 (1 branch, 2 call, 3 return) and `e_cond_true` is 1. A taken transfer gives `pc_cmd` = 1 (load target). In normal mode it also cancels the same two younger slots as R4.
- R6: A transfer with `e_cond_true` = 0, and no flag or pointer update, gives `pc_cmd` = 0 (step) and cancels nothing.
- R7: With `delay_slot_mode` = 1 nothing is cancelled:
  - a flag or pointer update gives `pc_cmd` = 0;
  - a taken transfer still gives `pc_cmd` = 1.
- R8: While `kill_ex` is 1, the four enables `ex_reg_we_o`, `ex_flag_we_o`, `ex_mem_we_o` and `ex_ptr_we_o` are 0. Otherwise each equals its input.
- R9: A hazard in a cancelled execute instruction is ignored: `pc_cmd` = 0 and `kill_if` = 0.
- R10: When a taken transfer and a flag or pointer update are in the same instruction, the transfer wins: `pc_cmd` = 1.
- R11: While reset is held, with quiet inputs, all kill outputs are 0 and `pc_cmd` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_slot_mode | input | 1 | 1 turns off all cancelling |
| d_src_a | input | REG_AW | Decode-stage source register, operand A |
| d_src_b | input | REG_AW | Decode-stage source register, operand B |
| e_reg_we | input | 1 | Execute instruction writes a register |
| e_dst | input | REG_AW | Execute instruction destination register |
| e_flag_we | input | 1 | Execute instruction writes flags |
| e_mem_we | input | 1 | Execute instruction writes memory |
| e_ptr_upd | input | 1 | Execute instruction updates the pointer register |
| e_xfer | input | 2 | Transfer kind: 0 none, 1 branch, 2 call, 3 return |
| e_cond_true | input | 1 | Transfer condition evaluated true |
| fwd_a | output | 1 | Forward ALU result into operand A |
| fwd_b | output | 1 | Forward ALU result into operand B |
| kill_if | output | 1 | Instruction being fetched is cancelled |
| kill_de | output | 1 | Decode-stage instruction is cancelled |
| kill_ex | output | 1 | Execute-stage instruction is cancelled |
| ex_reg_we_o | output | 1 | Gated register write enable |
| ex_flag_we_o | output | 1 | Gated flag write enable |
| ex_mem_we_o | output | 1 | Gated memory write enable |
| ex_ptr_we_o | output | 1 | Gated pointer update enable |
| pc_cmd | output | 2 | 0 step, 1 load target, 2 step back one |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a taken transfer and a flag or pointer update carried by the same execute instruction. The bench drives every combination of mode, flag write, pointer update, transfer kind and condition. It expects the program-counter command to follow the transfer whenever the transfer is taken.

The second pair is a hazard and the cancellation already in progress. The bench repeats the same hazard in the cycle after a squash. It judges that repeat as ignored from `pc_cmd`, `kill_if` and the gated enables. It also checks that forwarding from a cancelled producer is suppressed in that same cycle.

// File: rtl/hcu_pkg.sv
package hcu_pkg;

  // Younger slots cancelled by a hazard (fetch and decode).
  localparam int KILL_SLOTS = 2;

  typedef enum logic [1:0] {
    XF_NONE   = 2'd0,
    XF_BRANCH = 2'd1,
    XF_CALL   = 2'd2,
    XF_RETURN = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    PC_STEP = 2'd0,
    PC_LOAD = 2'd1,
    PC_BACK = 2'd2
  } pc_cmd_e;

endpackage

// File: rtl/hcu_fwd.sv
module hcu_fwd #(
  parameter int REG_AW = 3,
  parameter int NOPS   = 2
) (
  input  logic                           e_live,
  input  logic                           e_reg_we,
  input  logic [REG_AW-1:0]              e_dst,
  input  logic [NOPS-1:0][REG_AW-1:0]    src,
  output logic [NOPS-1:0]                fwd
);

  logic producer_ok;
  assign producer_ok = e_live & e_reg_we;

  // One comparator per ALU operand, no index is special.
  for (genvar i = 0; i < NOPS; i++) begin : g_op
    assign fwd[i] = producer_ok & (src[i] == e_dst);
  end

endmodule

// File: rtl/hcu_hazard.sv
module hcu_hazard
  import hcu_pkg::*;
(
  input  logic       e_live,
  input  logic       delay_slot_mode,
  input  logic       e_flag_we,
  input  logic       e_ptr_upd,
  input  logic [1:0] e_xfer,
  input  logic       e_cond_true,
  output logic       squash,
  output pc_cmd_e    cmd
);

  logic taken;
  logic state_hz;

  assign taken    = e_live & (xfer_e'(e_xfer) != XF_NONE) & e_cond_true;
  assign state_hz = e_live & (e_flag_we | e_ptr_upd);

  always_comb begin
    cmd    = PC_STEP;
    squash = 1'b0;
    if (taken) begin
      // Transfer has priority over a flag/pointer hazard.
      cmd    = PC_LOAD;
      squash = ~delay_slot_mode;
    end else if (state_hz && !delay_slot_mode) begin
      cmd    = PC_BACK;
      squash = 1'b1;
    end
  end

endmodule

// File: rtl/hcu_killchain.sv
module hcu_killchain #(
  parameter int DEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           squash,
  output logic [DEPTH:0] kill
);

  // mark_q[i] carries the cancel mark into slot i+1.
  logic [DEPTH-1:0] mark_q;
  logic [DEPTH-1:0] mark_d;

  for (genvar i = 0; i <= DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_young
      assign kill[i] = squash;
    end else if (i < DEPTH) begin : g_mid
      assign kill[i] = squash | mark_q[i-1];
    end else begin : g_old
      assign kill[i] = mark_q[i-1];
    end
  end

  always_comb begin
    mark_d = kill[DEPTH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= '0;
    end else begin
      mark_q <= mark_d;
    end
  end

endmodule

// File: rtl/hcu_ctrl.sv
module hcu_ctrl
  import hcu_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              delay_slot_mode,
  input  logic [REG_AW-1:0] d_src_a,
  input  logic [REG_AW-1:0] d_src_b,
  input  logic              e_reg_we,
  input  logic [REG_AW-1:0] e_dst,
  input  logic              e_flag_we,
  input  logic              e_mem_we,
  input  logic              e_ptr_upd,
  input  logic [1:0]        e_xfer,
  input  logic              e_cond_true,
  output logic              fwd_a,
  output logic              fwd_b,
  output logic              kill_if,
  output logic              kill_de,
  output logic              kill_ex,
  output logic              ex_reg_we_o,
  output logic              ex_flag_we_o,
  output logic              ex_mem_we_o,
  output logic              ex_ptr_we_o,
  output logic [1:0]        pc_cmd
);

  localparam int NOPS = 2;

  logic [KILL_SLOTS:0]            kill;
  logic                           e_live;
  logic                           squash;
  pc_cmd_e                        cmd;
  logic [NOPS-1:0][REG_AW-1:0]    srcs;
  logic [NOPS-1:0]                fwd;

  assign e_live = ~kill[KILL_SLOTS];
  assign srcs   = {d_src_b, d_src_a};

  hcu_fwd #(.REG_AW(REG_AW), .NOPS(NOPS)) u_fwd (
    .e_live   (e_live),
    .e_reg_we (e_reg_we),
    .e_dst    (e_dst),
    .src      (srcs),
    .fwd      (fwd)
  );

  hcu_hazard u_hz (
    .e_live          (e_live),
    .delay_slot_mode (delay_slot_mode),
    .e_flag_we       (e_flag_we),
    .e_ptr_upd       (e_ptr_upd),
    .e_xfer          (e_xfer),
    .e_cond_true     (e_cond_true),
    .squash          (squash),
    .cmd             (cmd)
  );

  hcu_killchain #(.DEPTH(KILL_SLOTS)) u_kill (
    .clk    (clk),
    .rst_n  (rst_n),
    .squash (squash),
    .kill   (kill)
  );

  assign fwd_a        = fwd[0];
  assign fwd_b        = fwd[1];
  assign kill_if      = kill[0];
  assign kill_de      = kill[1];
  assign kill_ex      = kill[KILL_SLOTS];
  assign ex_reg_we_o  = e_reg_we  & e_live;
  assign ex_flag_we_o = e_flag_we & e_live;
  assign ex_mem_we_o  = e_mem_we  & e_live;
  assign ex_ptr_we_o  = e_ptr_upd & e_live;
  assign pc_cmd       = cmd;

endmodule

// File: rtl/hcu_ctrl_chk.sv
module hcu_ctrl_chk
  import hcu_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              delay_slot_mode,
  input logic              e_flag_we,
  input logic              e_ptr_upd,
  input logic [1:0]        e_xfer,
  input logic              e_cond_true,
  input logic              fwd_a,
  input logic              fwd_b,
  input logic              kill_if,
  input logic              kill_de,
  input logic              kill_ex,
  input logic              ex_reg_we_o,
  input logic              ex_flag_we_o,
  input logic              ex_mem_we_o,
  input logic              ex_ptr_we_o,
  input logic [1:0]        pc_cmd
);

  a_r8_killed_no_writes: assert property (@(posedge clk) disable iff (!rst_n)
    kill_ex |-> !(ex_reg_we_o || ex_flag_we_o || ex_mem_we_o || ex_ptr_we_o));

  a_r4_fetch_mark_moves: assert property (@(posedge clk) disable iff (!rst_n)
    kill_if |=> kill_de);

  a_r4_decode_mark_moves: assert property (@(posedge clk) disable iff (!rst_n)
    kill_de |=> kill_ex);

  a_r9_killed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    kill_ex |-> (pc_cmd == PC_STEP) && !kill_if);

  a_r10_taken_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_ex && e_xfer != 2'd0 && e_cond_true) |-> pc_cmd == PC_LOAD);

  a_r7_no_new_kill: assert property (@(posedge clk) disable iff (!rst_n)
    delay_slot_mode |-> !kill_if);

  a_r1_no_fwd_from_killed: assert property (@(posedge clk) disable iff (!rst_n)
    kill_ex |-> !fwd_a && !fwd_b);

  a_r6_not_taken_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_ex && !e_cond_true && !e_flag_we && !e_ptr_upd)
      |-> (pc_cmd == PC_STEP) && !kill_if);

endmodule

bind hcu_ctrl hcu_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .delay_slot_mode (delay_slot_mode),
  .e_flag_we       (e_flag_we),
  .e_ptr_upd       (e_ptr_upd),
  .e_xfer          (e_xfer),
  .e_cond_true     (e_cond_true),
  .fwd_a           (fwd_a),
  .fwd_b           (fwd_b),
  .kill_if         (kill_if),
  .kill_de         (kill_de),
  .kill_ex         (kill_ex),
  .ex_reg_we_o     (ex_reg_we_o),
  .ex_flag_we_o    (ex_flag_we_o),
  .ex_mem_we_o     (ex_mem_we_o),
  .ex_ptr_we_o     (ex_ptr_we_o),
  .pc_cmd          (pc_cmd)
);

// File: tb/tb_hcu_ctrl.sv
module tb_hcu_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RAW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic delay_slot_mode;
  logic [RAW-1:0] d_src_a, d_src_b, e_dst;
  logic e_reg_we, e_flag_we, e_mem_we, e_ptr_upd, e_cond_true;
  logic [1:0] e_xfer;
  logic fwd_a, fwd_b, kill_if, kill_de, kill_ex;
  logic ex_reg_we_o, ex_flag_we_o, ex_mem_we_o, ex_ptr_we_o;
  logic [1:0] pc_cmd;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcu_ctrl #(.REG_AW(RAW)) dut (
    .clk(clk), .rst_n(rst_n), .delay_slot_mode(delay_slot_mode),
    .d_src_a(d_src_a), .d_src_b(d_src_b), .e_reg_we(e_reg_we), .e_dst(e_dst),
    .e_flag_we(e_flag_we), .e_mem_we(e_mem_we), .e_ptr_upd(e_ptr_upd),
    .e_xfer(e_xfer), .e_cond_true(e_cond_true),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .kill_if(kill_if), .kill_de(kill_de),
    .kill_ex(kill_ex), .ex_reg_we_o(ex_reg_we_o), .ex_flag_we_o(ex_flag_we_o),
    .ex_mem_we_o(ex_mem_we_o), .ex_ptr_we_o(ex_ptr_we_o), .pc_cmd(pc_cmd)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    d_src_a = '0; d_src_b = '0; e_dst = '0;
    e_reg_we = 1'b0; e_flag_we = 1'b0; e_mem_we = 1'b0;
    e_ptr_upd = 1'b0; e_xfer = 2'd0; e_cond_true = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    delay_slot_mode = 1'b0;
    quiet();
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "kill_if", int'(kill_if), 0);
    check("R11", "kill_de", int'(kill_de), 0);
    check("R11", "kill_ex", int'(kill_ex), 0);
    check("R11", "pc_cmd", int'(pc_cmd), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3: exhaustive forwarding sweep in both modes
    for (int m = 0; m < 2; m++) begin
      delay_slot_mode = m[0];
      for (int w = 0; w < 2; w++) begin
        for (int d = 0; d < 8; d++) begin
          for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
              e_reg_we = w[0]; e_dst = 3'(d); d_src_a = 3'(a); d_src_b = 3'(b);
              #1;
              check(m == 1 ? "R3" : "R1", "fwd_a", int'(fwd_a), (w == 1 && d == a) ? 1 : 0);
              check(m == 1 ? "R3" : "R2", "fwd_b", int'(fwd_b), (w == 1 && d == b) ? 1 : 0);
            end
          end
        end
      end
    end
    quiet();
    @(negedge clk);

    // R4..R10: every hazard combination, followed through the kill window
    for (int c = 0; c < 64; c++) begin
      logic fl, pt, cd, taken, sq;
      logic [1:0] xf;
      int exp_cmd;
      fl = c[1]; pt = c[2]; xf = c[4:3]; cd = c[5];
      taken = (xf != 2'd0) && cd;
      sq = !c[0] && (taken || fl || pt);
      exp_cmd = taken ? 1 : ((fl || pt) && !c[0]) ? 2 : 0;

      @(negedge clk);
      delay_slot_mode = c[0];
      e_flag_we = fl; e_ptr_upd = pt; e_xfer = xf; e_cond_true = cd;
      e_reg_we = 1'b1; e_mem_we = 1'b1; e_dst = 3'd5; d_src_a = 3'd5; d_src_b = 3'd2;
      #1;
      check(taken && (fl || pt) ? "R10" : taken ? "R5" : c[0] ? "R7" : (fl || pt) ? "R4" : "R6",
            "pc_cmd", int'(pc_cmd), exp_cmd);
      check(c[0] ? "R7" : "R4", "kill_if", int'(kill_if), int'(sq));
      check(c[0] ? "R7" : "R5", "kill_de", int'(kill_de), int'(sq));
      check("R8", "ex_flag_we_o pass", int'(ex_flag_we_o), int'(fl));
      check("R8", "ex_ptr_we_o pass", int'(ex_ptr_we_o), int'(pt));
      check("R8", "ex_mem_we_o pass", int'(ex_mem_we_o), 1);
      check("R3", "fwd_a live", int'(fwd_a), 1);

      @(negedge clk);
      if (!sq) quiet();
      #1;
      check("R4", "kill_ex t+1", int'(kill_ex), int'(sq));
      check("R4", "kill_de t+1", int'(kill_de), int'(sq));
      check("R9", "kill_if t+1", int'(kill_if), 0);
      check("R9", "pc_cmd t+1", int'(pc_cmd), 0);
      check("R8", "ex_reg_we_o", int'(ex_reg_we_o), sq ? 0 : int'(e_reg_we));
      check("R8", "ex_mem_we_o", int'(ex_mem_we_o), sq ? 0 : int'(e_mem_we));
      check("R8", "ex_flag_we_o", int'(ex_flag_we_o), 0);
      check("R8", "ex_ptr_we_o", int'(ex_ptr_we_o), 0);
      check("R1", "fwd_a from killed", int'(fwd_a), sq ? 0 : int'(e_reg_we && e_dst == d_src_a));

      @(negedge clk);
      quiet();
      #1;
      check("R4", "kill_ex t+2", int'(kill_ex), int'(sq));
      check("R4", "kill_de t+2", int'(kill_de), 0);
      check("R6", "kill_if t+2", int'(kill_if), 0);

      @(negedge clk);
      #1;
      check("R4", "kill_ex t+3", int'(kill_ex), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule